// File: doc/BRIEF.md
# Dual-Window ROM Page Mapper

This block sits between a nibble-addressed CPU and a large ROM. It shows that ROM through two 256K-nibble windows of the 20-bit CPU address space. The low window covers CPU addresses 0x00000-0x3FFFF and the high window covers 0x40000-0x7FFFF. Both windows repeat at 0x80000. Each window has its own page number. Software selects the pages by touching a small switcher region. The page numbers come from the address offset of that access. The data of the access plays no part.

A mode input selects how the block behaves. In window mode, a write to the switcher region loads the page latch. In legacy mode, a read loads it instead. Legacy mode also has its own mapping rules:
- The ROM is mapped flat, either 512K nibbles mirrored or the full 20-bit space.
- The latch drives an expansion-port page offset and a port enable.

The CPU address goes through one register stage. The page latch takes effect for addresses presented in the cycle after the switcher access.

Top module: `rom_bank_switcher`

## Requirements
- R1: Bit 0 of the 7-bit switcher offset is discarded. The latched value equals the offset with bit 0 forced to 0, so two offsets that differ only in bit 0 select the same mapping.
- R2: In window mode, a CPU address with bit 18 clear uses the low page. The low page is latched bits 6:5, giving a value from 0 to 3.
- R3: In window mode, a CPU address with bit 18 set uses the high page. The high page is latched bits 4:1, giving a value from 0 to 15.
- R4: In window mode, the ROM address is page × 0x40000 + (CPU address & 0x3FFFF). CPU address bit 19 is ignored, so both windows mirror at 0x80000.
- R5: In window mode (legacy_mode=0), only a strobe with sw_write=1 loads the latch. In legacy mode (legacy_mode=1), only a strobe with sw_write=0 loads it. A strobe of the other kind leaves the mapping unchanged.
- R6: In legacy mode, port_en equals latched bit 6 AND NOT full_rom. port_offset equals (latched value mod PORT_PAGES) × 0x10000.
- R7: In legacy mode with full_rom=1, the ROM address equals the 20-bit CPU address and port_en is 0. With full_rom=0, the ROM address is CPU address & 0x7FFFF.
- R8: Synchronous reset clears the latch and all registered outputs to 0.
- R9: map_update is high for exactly one cycle after an accepted access that changes the latched value, and is low otherwise.
- R10: rom_addr is registered one cycle after cpu_addr. An address presented in the same cycle as an accepted access is translated with the old mapping. From the next cycle on, the new mapping applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 0 = write-triggered window mode, 1 = read-triggered legacy mode |
| full_rom | input | 1 | Legacy only: map ROM over the whole 20-bit space and disable the port |
| sw_strobe | input | 1 | Switcher-region access in this cycle |
| sw_write | input | 1 | 1 = the access is a write, 0 = a read |
| sw_offset | input | 7 | Address offset of the switcher access |
| cpu_addr | input | 20 | CPU nibble address to translate |
| rom_addr | output | 22 | Physical ROM nibble address, registered |
| port_offset | output | 19 | Expansion-port offset in nibbles, registered |
| port_en | output | 1 | Expansion-port enable, registered |
| map_update | output | 1 | One-cycle pulse when the latched mapping changed |

## Verification
A switcher access and an address translation can occur in the same cycle. The question in that case is which mapping the translation uses. The bench provokes this by driving a high-window CPU address in the very cycle that a write loads a different page. The rom_addr captured at that edge must match the old page. With the address held, the next edge must match the new page. The bench also sweeps every even latch value in both modes, with bit 0 of the offset toggled, and checks that strobes of the wrong kind and repeated values leave the mapping and map_update alone.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  // Access kinds that may load the page latch.
  typedef enum logic {
    LOAD_ON_WRITE = 1'b0,
    LOAD_ON_READ  = 1'b1
  } load_kind_e;

  // Mapping style selected by the mode pin.
  typedef enum logic {
    MAP_WINDOWED = 1'b0,
    MAP_LEGACY   = 1'b1
  } map_style_e;

  // Clear the ignored low bit of a switcher offset.
  function automatic logic [6:0] strip_low(input logic [6:0] ofs);
    return {ofs[6:1], 1'b0};
  endfunction
endpackage

// File: rtl/rbs_latch.sv
module rbs_latch
  import rbs_pkg::*;
#(
  parameter int OFS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             is_write,
  input  logic             legacy,
  input  logic [OFS_W-1:0] offset,
  output logic [OFS_W-1:0] latch_o,
  output logic             upd_o
);
  load_kind_e      want_kind;
  logic            accept;
  logic [OFS_W-1:0] next_val;
  logic [OFS_W-1:0] latch_q;
  logic            upd_q;

  assign want_kind = (legacy == MAP_LEGACY) ? LOAD_ON_READ : LOAD_ON_WRITE;
  assign accept    = strobe && ((is_write ? LOAD_ON_WRITE : LOAD_ON_READ) == want_kind);
  assign next_val  = {offset[OFS_W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= accept && (next_val != latch_q);
      if (accept) latch_q <= next_val;
    end
  end

  assign latch_o = latch_q;
  assign upd_o   = upd_q;

  // R5
  ignored_access_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobe && (is_write != legacy)) |=> $stable(latch_q));
  // R9
  upd_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> $past(strobe));
  // R1
  low_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    latch_q[0] == 1'b0);
endmodule

// File: rtl/rbs_window_xlate.sv
module rbs_window_xlate #(
  parameter int OFS_W  = 7,
  parameter int CPU_AW = 20,
  parameter int WIN_AW = 18,
  parameter int LO_LSB = 5,
  parameter int LO_W   = 2,
  parameter int HI_LSB = 1,
  parameter int HI_W   = 4,
  parameter int ROM_AW = WIN_AW + HI_W
) (
  input  logic [OFS_W-1:0]  latch_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  output logic [ROM_AW-1:0] phys_o
);
  localparam int NWIN = 2;
  localparam int PG_W = ROM_AW - WIN_AW;

  logic [PG_W-1:0] page [NWIN];

  // Window 0 is the low window, window 1 the high window.
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int FLSB = (w == 0) ? LO_LSB : HI_LSB;
    localparam int FW   = (w == 0) ? LO_W   : HI_W;
    assign page[w] = PG_W'(latch_i[FLSB+FW-1:FLSB]);
  end

  logic sel;
  assign sel    = cpu_addr_i[WIN_AW];
  assign phys_o = {page[sel], cpu_addr_i[WIN_AW-1:0]};
endmodule

// File: rtl/rbs_port_xlate.sv
module rbs_port_xlate #(
  parameter int OFS_W      = 7,
  parameter int PORT_PAGES = 6,
  parameter int PAGE_SHIFT = 16,
  parameter int EN_BIT     = 6,
  parameter int IDX_W      = (PORT_PAGES > 1) ? $clog2(PORT_PAGES) : 1,
  parameter int POFS_W     = IDX_W + PAGE_SHIFT
) (
  input  logic [OFS_W-1:0]  latch_i,
  input  logic              full_rom_i,
  output logic [POFS_W-1:0] ofs_o,
  output logic              en_o
);
  logic [OFS_W-1:0] idx;

  assign idx   = OFS_W'(latch_i % OFS_W'(PORT_PAGES));
  assign ofs_o = {idx[IDX_W-1:0], {PAGE_SHIFT{1'b0}}};
  assign en_o  = latch_i[EN_BIT] && !full_rom_i;
endmodule

// File: rtl/rom_bank_switcher.sv
module rom_bank_switcher
  import rbs_pkg::*;
#(
  parameter int OFS_W      = 7,
  parameter int CPU_AW     = 20,
  parameter int WIN_AW     = 18,
  parameter int LO_LSB     = 5,
  parameter int LO_W       = 2,
  parameter int HI_LSB     = 1,
  parameter int HI_W       = 4,
  parameter int PORT_PAGES = 6,
  parameter int PAGE_SHIFT = 16,
  parameter int ROM_AW     = WIN_AW + HI_W,
  parameter int POFS_W     = $clog2(PORT_PAGES) + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legacy_mode,
  input  logic              full_rom,
  input  logic              sw_strobe,
  input  logic              sw_write,
  input  logic [OFS_W-1:0]  sw_offset,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [POFS_W-1:0] port_offset,
  output logic              port_en,
  output logic              map_update
);
  localparam int LEGACY_AW = WIN_AW + 1;
  localparam int IDX_W     = POFS_W - PAGE_SHIFT;

  logic [OFS_W-1:0]  latch;
  logic [ROM_AW-1:0] win_phys;
  logic [ROM_AW-1:0] phys_d;
  logic [POFS_W-1:0] pofs_d;
  logic              pen_d;
  map_style_e        style;

  rbs_latch #(.OFS_W(OFS_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .strobe   (sw_strobe),
    .is_write (sw_write),
    .legacy   (legacy_mode),
    .offset   (sw_offset),
    .latch_o  (latch),
    .upd_o    (map_update)
  );

  rbs_window_xlate #(
    .OFS_W(OFS_W), .CPU_AW(CPU_AW), .WIN_AW(WIN_AW),
    .LO_LSB(LO_LSB), .LO_W(LO_W), .HI_LSB(HI_LSB), .HI_W(HI_W),
    .ROM_AW(ROM_AW)
  ) u_win (
    .latch_i    (latch),
    .cpu_addr_i (cpu_addr),
    .phys_o     (win_phys)
  );

  rbs_port_xlate #(
    .OFS_W(OFS_W), .PORT_PAGES(PORT_PAGES), .PAGE_SHIFT(PAGE_SHIFT),
    .EN_BIT(OFS_W-1), .IDX_W(IDX_W), .POFS_W(POFS_W)
  ) u_port (
    .latch_i    (latch),
    .full_rom_i (full_rom),
    .ofs_o      (pofs_d),
    .en_o       (pen_d)
  );

  assign style = map_style_e'(legacy_mode);

  always_comb begin
    if (style == MAP_LEGACY) begin
      if (full_rom) phys_d = ROM_AW'(cpu_addr);
      else          phys_d = ROM_AW'(cpu_addr[LEGACY_AW-1:0]);
    end else begin
      phys_d = win_phys;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr    <= '0;
      port_offset <= '0;
      port_en     <= 1'b0;
    end else begin
      rom_addr    <= phys_d;
      port_offset <= pofs_d;
      port_en     <= (style == MAP_LEGACY) && pen_d;
    end
  end

  // R7
  full_rom_chk: assert property (@(posedge clk) disable iff (rst)
    (legacy_mode && full_rom) |=> (rom_addr == ROM_AW'($past(cpu_addr)) && !port_en));
  // R7
  legacy_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (legacy_mode && !full_rom) |=> (rom_addr[ROM_AW-1:LEGACY_AW] == '0));
  // R4
  window_offset_chk: assert property (@(posedge clk) disable iff (rst)
    !legacy_mode |=> (rom_addr[WIN_AW-1:0] == $past(cpu_addr[WIN_AW-1:0])));
  // R6
  port_off_window_chk: assert property (@(posedge clk) disable iff (rst)
    !legacy_mode |=> !port_en);
endmodule

// File: tb/sim_rom_bank_switcher.sv
module sim_rom_bank_switcher;
  localparam int PP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        legacy_mode = 1'b0;
  logic        full_rom = 1'b0;
  logic        sw_strobe = 1'b0;
  logic        sw_write = 1'b0;
  logic [6:0]  sw_offset = '0;
  logic [19:0] cpu_addr = '0;
  logic [21:0] rom_addr;
  logic [18:0] port_offset;
  logic        port_en;
  logic        map_update;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int m;  // model of the latched value

  always #5 clk = ~clk;

  rom_bank_switcher #(.PORT_PAGES(PP)) u0 (
    .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .full_rom(full_rom),
    .sw_strobe(sw_strobe), .sw_write(sw_write), .sw_offset(sw_offset),
    .cpu_addr(cpu_addr), .rom_addr(rom_addr), .port_offset(port_offset),
    .port_en(port_en), .map_update(map_update)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_win(input int l, input int a);
    int pg;
    pg = ((a >> 18) & 1) ? ((l >> 1) & 15) : ((l >> 5) & 3);
    return pg * 32'h40000 + (a & 32'h3FFFF);
  endfunction

  // Called at a negedge; returns at the negedge after the access edge.
  task automatic access(input int off, input bit wr);
    sw_offset = 7'(off);
    sw_write  = wr;
    sw_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sw_strobe = 1'b0;
  endtask

  task automatic xlate(input int a);
    cpu_addr = 20'(a);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int x;
    int a;
    int nv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(rom_addr, 0, "R8 rom_addr");
    chk(port_offset, 0, "R8 port_offset");
    chk(port_en, 0, "R8 port_en");
    chk(map_update, 0, "R8 map_update");
    m = 0;
    xlate(32'h7FFFF);
    chk(rom_addr, exp_win(0, 32'h7FFFF), "R8 latch zero after reset");

    // Window mode sweep over every even latch value, toggling bit 0 (R1-R4, R9)
    legacy_mode = 1'b0;
    for (int k = 0; k < 64; k++) begin
      nv = 2 * k;
      access(nv | (k & 1), 1'b1);
      chk(map_update, (nv != m) ? 1 : 0, "R9 pulse on change");
      m = nv;
      x = (k * 32'h1357 + 32'h0ABC) & 32'h3FFFF;
      for (int q = 0; q < 4; q++) begin
        a = q * 32'h40000 + x;
        xlate(a);
        chk(rom_addr, exp_win(m, a), (q[0]) ? "R3 high window" : "R2 low window");
      end
      chk(port_en, 0, "R6 port off in window mode");
    end

    // R1: same value with bit 0 set gives no change
    access(m | 1, 1'b1);
    chk(map_update, 0, "R1 bit0 ignored no pulse");
    xlate(32'h40123);
    chk(rom_addr, exp_win(m, 32'h40123), "R1 bit0 ignored mapping");

    // R5: a read in window mode is ignored
    access(32'h2A, 1'b0);
    chk(map_update, 0, "R5 read ignored pulse");
    xlate(32'h4F00D);
    chk(rom_addr, exp_win(m, 32'h4F00D), "R5 read ignored hi");
    xlate(32'h0F00D);
    chk(rom_addr, exp_win(m, 32'h0F00D), "R5 read ignored lo");

    // R10: switcher access and translation in the same cycle
    access(32'h00, 1'b1);
    m = 0;
    cpu_addr  = 20'h4_1234;
    sw_offset = 7'h1E;
    sw_write  = 1'b1;
    sw_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sw_strobe = 1'b0;
    chk(rom_addr, exp_win(0, 32'h41234), "R10 same-cycle uses old map");
    chk(map_update, 1, "R9 pulse same-cycle case");
    m = 32'h1E;
    @(posedge clk);
    @(negedge clk);
    chk(rom_addr, exp_win(m, 32'h41234), "R10 next cycle uses new map");
    chk(map_update, 0, "R9 pulse lasts one cycle");

    // Legacy mode sweep (R5, R6, R7)
    legacy_mode = 1'b1;
    full_rom    = 1'b0;
    for (int k = 0; k < 64; k++) begin
      nv = 2 * k;
      access(nv | ((k >> 1) & 1), 1'b0);
      chk(map_update, (nv != m) ? 1 : 0, "R9 legacy pulse");
      m = nv;
      a = (k * 32'h2B3D1 + 32'h80000) & 32'hFFFFF;
      xlate(a);
      chk(rom_addr, a & 32'h7FFFF, "R7 legacy mirrored ROM");
      chk(port_en, (m >> 6) & 1, "R6 port enable");
      chk(port_offset, (m % PP) * 32'h10000, "R6 port offset modulo");
    end

    // R5: write ignored in legacy mode
    access(32'h12, 1'b1);
    chk(map_update, 0, "R5 legacy write ignored pulse");
    xlate(32'h00000);
    chk(port_offset, (m % PP) * 32'h10000, "R5 legacy write ignored offset");

    // R7: full-ROM control bit
    full_rom = 1'b1;
    for (int k = 0; k < 8; k++) begin
      a = k * 32'h1FFFF + 32'h80001;
      a = a & 32'hFFFFF;
      xlate(a);
      chk(rom_addr, a, "R7 full 20-bit ROM");
      chk(port_en, 0, "R7 port disabled by full_rom");
    end

    // R8: reset again clears the latch
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    legacy_mode = 1'b0;
    full_rom    = 1'b0;
    xlate(32'hC5555);
    chk(rom_addr, exp_win(0, 32'hC5555), "R8 latch cleared by reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule